// File: doc/BRIEF.md
# Coarse/Fine Phase Error Counter

This block measures the time offset between the falling edges of a reference pulse train and a motor feedback pulse train. It expresses that offset as two offset-binary words. Both inputs are asynchronous. Each passes through a two-flop synchronizer and a falling-edge detector. A small phase detector then opens a measurement window on the first falling edge and closes it on the falling edge of the other input. While the window is open, a cascaded pair of saturating counters steps once per system clock. The fine counter moves first. The coarse counter moves only after the fine counter has run to the end of its range.

When the window opens on the reference edge, the error is positive and the counters count up. When it opens on the feedback edge, the error is negative and they count down. The closing edge copies both counters into output holding registers and pulses a one-clock valid strobe. It also reloads both counters to mid-scale (0x80), which stands for zero error. The latched words change once per feedback cycle. A downstream converter (not part of this block) turns them into a speed command.

Top module: `phase_err_counter`

## Requirements
- R1: While rst_n is low, and after it rises, fine_err and coarse_err read 0x80 and err_valid is 0.
- R2: In a positive measurement, the reference input falls and the feedback input falls D clocks later. The latched fine_err is then 0x80 + min(D,127).
- R3: The coarse counter stays still until the fine counter sits at its end of range. In a positive measurement, coarse_err is 0x80 + min(max(D-127,0),127).
- R4: Neither counter wraps. In a positive measurement with D of 254 or more, both words latch 0xFF. In a negative measurement with D of 256 or more, both latch 0x00.
- R5: In a negative measurement, the feedback input falls and the reference input falls D clocks later. fine_err is 0x80 - min(D,128) and coarse_err is 0x80 - min(max(D-128,0),128).
- R6: If both inputs fall in the same clock while no window is open, both words latch 0x80.
- R7: After reset, the direction is forced upward. A feedback falling edge that arrives before any measurement has completed opens no window: err_valid stays 0 and both outputs keep their values.
- R8: A second falling edge of the input that opened the window, arriving while the window is open, is ignored. The result is the same as if it had not occurred.
- R9: err_valid is high for exactly one clock, in the cycle in which fine_err and coarse_err take new values. The outputs hold their values between strobes.
- R10: After every latch, both counters restart from 0x80, so each measurement is independent of the one before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_in | input | 1 | Reference pulse train, asynchronous |
| fb_in | input | 1 | Motor feedback pulse train, asynchronous |
| fine_err | output | 8 | Latched fine error word, offset binary |
| coarse_err | output | 8 | Latched coarse error word, offset binary |
| err_valid | output | 1 | One-clock strobe when new words are latched |

## Verification
The hardest situations to reach from the ports are the ones where the coarse counter runs into its own limit. This needs a window longer than the full fine range plus the full coarse range: 254 clocks upward, or 256 clocks downward. The stimulus reaches them with directed separations just below, at, and beyond those limits, in both directions, and also spreads random separations of up to 320 clocks. The ignored feedback edge straight after reset is also driven directly, followed at once by a normal measurement. This shows that the ignored edge left no trace.

// File: rtl/phase_err_pkg.sv
// Package: shared widths and phase detector state encoding.
// Assumes: counters are offset-binary with zero error at mid-scale.
package phase_err_pkg;
    localparam int ERR_W = 8;

    typedef enum logic [1:0] {
        PD_IDLE = 2'd0,
        PD_UP   = 2'd1,
        PD_DN   = 2'd2
    } pd_state_t;
endpackage

// File: rtl/edge_sync.sv
// Module: edge_sync
// Brings one asynchronous input into the clk domain through a chain of
// flops and emits a single-cycle strobe on each falling edge.
// Assumes: the input stays at each level for at least two clocks.
module edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic fall_pulse
);
    logic [STAGES-1:0] chain;
    logic              last_q;

    // First synchronizer flop samples the raw input.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b1;
        else        chain[0] <= async_in;
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_sync
            // Each further stage resamples the one before it.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= 1'b1;
                else        chain[g] <= chain[g-1];
            end
        end
    endgenerate

    // Keep the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b1;
        else        last_q <= chain[STAGES-1];
    end

    assign fall_pulse = last_q & ~chain[STAGES-1];
endmodule

// File: rtl/phase_detect.sv
// Module: phase_detect
// Opens a measurement window on the first falling edge and closes it on the
// falling edge of the other input. Emits count-up/count-down enables and a
// close strobe. Until the first measurement completes, only the reference
// may open a window, so the direction starts upward.
// Assumes: strobes are single-cycle and already synchronized.
module phase_detect
    import phase_err_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ref_fall,
    input  logic fb_fall,
    output logic step_up,
    output logic step_dn,
    output logic close_win
);
    pd_state_t state_q, state_d;
    logic      armed_q;

    // Next-state and output decode for the window state machine.
    always_comb begin
        state_d   = state_q;
        step_up   = 1'b0;
        step_dn   = 1'b0;
        close_win = 1'b0;
        unique case (state_q)
            PD_IDLE: begin
                if (ref_fall && fb_fall) begin
                    close_win = 1'b1;
                end else if (ref_fall) begin
                    state_d = PD_UP;
                    step_up = 1'b1;
                end else if (fb_fall && armed_q) begin
                    state_d = PD_DN;
                    step_dn = 1'b1;
                end
            end
            PD_UP: begin
                if (fb_fall) begin
                    close_win = 1'b1;
                    state_d   = PD_IDLE;
                end else begin
                    step_up = 1'b1;
                end
            end
            PD_DN: begin
                if (ref_fall) begin
                    close_win = 1'b1;
                    state_d   = PD_IDLE;
                end else begin
                    step_dn = 1'b1;
                end
            end
            default: state_d = PD_IDLE;
        endcase
    end

    // Window state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PD_IDLE;
        else        state_q <= state_d;
    end

    // Armed flag: set after the first completed measurement.
    always_ff @(posedge clk) begin
        if (!rst_n)         armed_q <= 1'b0;
        else if (close_win) armed_q <= 1'b1;
    end

    assert_dir_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_up && step_dn));

    assert_first_dir_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PD_IDLE && !armed_q && fb_fall && !ref_fall) |=> (state_q == PD_IDLE));
endmodule

// File: rtl/cascade_counter.sv
// Module: cascade_counter
// A fine and a coarse saturating up/down counter. The coarse counter steps
// only when the fine counter is pinned at the end of range for the current
// direction. A load restores both counters to mid-scale.
// Assumes: step_up and step_dn are never high together.
module cascade_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_up,
    input  logic         step_dn,
    input  logic         reload,
    output logic [W-1:0] fine_q,
    output logic [W-1:0] coarse_q
);
    localparam logic [W-1:0] MID  = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] TOP  = {W{1'b1}};
    localparam logic [W-1:0] BOT  = {W{1'b0}};

    logic fine_at_top, fine_at_bot, coarse_go_up, coarse_go_dn;

    assign fine_at_top  = (fine_q == TOP);
    assign fine_at_bot  = (fine_q == BOT);
    assign coarse_go_up = step_up && fine_at_top && (coarse_q != TOP);
    assign coarse_go_dn = step_dn && fine_at_bot && (coarse_q != BOT);

    // Fine counter: saturating step in the requested direction.
    always_ff @(posedge clk) begin
        if (!rst_n || reload)             fine_q <= MID;
        else if (step_up && !fine_at_top) fine_q <= fine_q + 1'b1;
        else if (step_dn && !fine_at_bot) fine_q <= fine_q - 1'b1;
    end

    // Coarse counter: steps only while the fine counter is pinned.
    always_ff @(posedge clk) begin
        if (!rst_n || reload)  coarse_q <= MID;
        else if (coarse_go_up) coarse_q <= coarse_q + 1'b1;
        else if (coarse_go_dn) coarse_q <= coarse_q - 1'b1;
    end

    assert_coarse_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!reload && !(step_up && fine_q == TOP) && !(step_dn && fine_q == BOT))
        |=> $stable(coarse_q));

    assert_no_wrap_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!reload && step_up && fine_q == TOP && coarse_q == TOP)
        |=> (fine_q == TOP && coarse_q == TOP));

    assert_no_wrap_dn_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!reload && step_dn && fine_q == BOT && coarse_q == BOT)
        |=> (fine_q == BOT && coarse_q == BOT));
endmodule

// File: rtl/phase_err_counter.sv
// Module: phase_err_counter (top)
// Synchronizes the reference and feedback pulse trains, measures the time
// between their falling edges with cascaded fine/coarse counters, and
// latches both words together with a one-clock valid strobe.
// Assumes: each input holds each level for at least two clocks.
module phase_err_counter
    import phase_err_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_in,
    input  logic             fb_in,
    output logic [ERR_W-1:0] fine_err,
    output logic [ERR_W-1:0] coarse_err,
    output logic             err_valid
);
    localparam logic [ERR_W-1:0] MID = {1'b1, {(ERR_W-1){1'b0}}};

    logic             ref_fall, fb_fall;
    logic             step_up, step_dn, close_win;
    logic [ERR_W-1:0] fine_cnt, coarse_cnt;

    edge_sync #(.STAGES(2)) u_ref_sync (
        .clk(clk), .rst_n(rst_n), .async_in(ref_in), .fall_pulse(ref_fall)
    );

    edge_sync #(.STAGES(2)) u_fb_sync (
        .clk(clk), .rst_n(rst_n), .async_in(fb_in), .fall_pulse(fb_fall)
    );

    phase_detect u_pd (
        .clk(clk), .rst_n(rst_n),
        .ref_fall(ref_fall), .fb_fall(fb_fall),
        .step_up(step_up), .step_dn(step_dn), .close_win(close_win)
    );

    cascade_counter #(.W(ERR_W)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .step_up(step_up), .step_dn(step_dn), .reload(close_win),
        .fine_q(fine_cnt), .coarse_q(coarse_cnt)
    );

    // Output holding registers: capture counters when the window closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fine_err   <= MID;
            coarse_err <= MID;
        end else if (close_win) begin
            fine_err   <= fine_cnt;
            coarse_err <= coarse_cnt;
        end
    end

    // Valid strobe: high for the cycle in which new words appear.
    always_ff @(posedge clk) begin
        if (!rst_n) err_valid <= 1'b0;
        else        err_valid <= close_win;
    end

    assert_valid_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |=> !err_valid);

    assert_hold_between_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !err_valid |-> ($stable(fine_err) && $stable(coarse_err)));

    assert_restart_mid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> (fine_cnt == MID && coarse_cnt == MID));
endmodule

// File: tb/phase_err_counter_bench.sv
// Bench for phase_err_counter: directed corners plus seeded random windows.
module phase_err_counter_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_in = 1'b1;
    logic       fb_in = 1'b1;
    logic [7:0] fine_err, coarse_err;
    logic       err_valid;

    int vectors = 0;
    int misses  = 0;
    int cycles  = 0;
    bit done_flag = 1'b0;

    always #2.5 clk = ~clk;

    phase_err_counter u_phase_err_counter (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
        .fine_err(fine_err), .coarse_err(coarse_err), .err_valid(err_valid)
    );

    // Watchdog: an overlong run is a failed check.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done_flag) begin
            misses = misses + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    function automatic int clampi(int v, int lo, int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    // Expected {coarse, fine} for a window of d clocks.
    function automatic logic [15:0] expect_words(bit up, int d);
        int f, c;
        if (up) begin
            f = 128 + clampi(d, 0, 127);
            c = 128 + clampi(d - 127, 0, 127);
        end else begin
            f = 128 - clampi(d, 0, 128);
            c = 128 - clampi(d - 128, 0, 128);
        end
        return {c[7:0], f[7:0]};
    endfunction

    task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
        vectors = vectors + 1;
        if (act !== exp) begin
            misses = misses + 1;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic check1(string req, logic act, logic exp);
        vectors = vectors + 1;
        if (act !== exp) begin
            misses = misses + 1;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    // One measurement: opener falls, closer falls d clocks later.
    task automatic measure(bit up, int d, bit reopen, string req);
        logic [15:0] exp;
        bit seen;
        exp = expect_words(up, d);
        @(negedge clk);
        if (d == 0) begin
            ref_in = 1'b0; fb_in = 1'b0;
        end else begin
            if (up) ref_in = 1'b0; else fb_in = 1'b0;
            for (int i = 1; i <= d; i++) begin
                @(negedge clk);
                if (reopen && i == 5) begin
                    if (up) ref_in = 1'b1; else fb_in = 1'b1;
                end
                if (reopen && i == 10) begin
                    if (up) ref_in = 1'b0; else fb_in = 1'b0;
                end
            end
            if (up) fb_in = 1'b0; else ref_in = 1'b0;
        end
        seen = 1'b0;
        for (int k = 0; k < 10 && !seen; k++) begin
            @(negedge clk);
            if (err_valid) seen = 1'b1;
        end
        check1({req, " valid seen"}, seen, 1'b1);
        check8({req, " fine"}, fine_err, exp[7:0]);
        check8({req, " coarse"}, coarse_err, exp[15:8]);
        @(negedge clk);
        check1("R9 valid one clock", err_valid, 1'b0);
        check8("R9 fine held", fine_err, exp[7:0]);
        ref_in = 1'b1; fb_in = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        bit seen;
        bit up;
        int d;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        check8("R1 fine in reset", fine_err, 8'h80);
        check8("R1 coarse in reset", coarse_err, 8'h80);
        check1("R1 valid in reset", err_valid, 1'b0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check8("R1 fine after reset", fine_err, 8'h80);
        check1("R1 valid after reset", err_valid, 1'b0);

        // R7: feedback edge before any measurement is ignored.
        fb_in = 1'b0;
        seen = 1'b0;
        for (int k = 0; k < 15; k++) begin
            @(negedge clk);
            if (err_valid) seen = 1'b1;
        end
        check1("R7 no window from early feedback", seen, 1'b0);
        check8("R7 fine unchanged", fine_err, 8'h80);
        fb_in = 1'b1;
        repeat (5) @(negedge clk);
        measure(1'b1, 40, 1'b0, "R7 first up after ignored edge");

        // Directed corners.
        measure(1'b1, 0,   1'b0, "R6 simultaneous");
        measure(1'b1, 1,   1'b0, "R2 one clock up");
        measure(1'b1, 127, 1'b0, "R2 fine full");
        measure(1'b1, 128, 1'b0, "R3 first coarse step");
        measure(1'b1, 200, 1'b0, "R3 coarse mid");
        measure(1'b1, 254, 1'b0, "R4 up limit");
        measure(1'b1, 300, 1'b0, "R4 up saturate");
        measure(1'b0, 1,   1'b0, "R5 one clock down");
        measure(1'b0, 128, 1'b0, "R5 fine empty");
        measure(1'b0, 129, 1'b0, "R5 first coarse down");
        measure(1'b0, 256, 1'b0, "R4 down limit");
        measure(1'b0, 310, 1'b0, "R4 down saturate");
        measure(1'b1, 60,  1'b1, "R8 reopen up ignored");
        measure(1'b0, 60,  1'b1, "R8 reopen down ignored");
        measure(1'b1, 3,   1'b0, "R10 fresh after saturate");

        // Seeded random windows.
        for (int n = 0; n < 60; n++) begin
            up = ($urandom % 2) == 1;
            d  = int'($urandom % 321);
            measure(up, d, 1'b0, up ? "R2 R3 random up" : "R5 random down");
        end

        done_flag = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule